// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Frequency Divider

This block divides a fast input clock by a programmable integer ratio and emits one single-cycle pulse per division period, meant for the feedback input of a phase/frequency detector. It is built the way a dual-modulus synthesizer divider is built: a prescaler that divides by 2^P_W or 2^P_W+1 feeds a main counter and a swallow counter. During the first A prescaler periods of a division cycle, the swallow counter holds the modulus control high, so the prescaler counts one extra input cycle each time. For the remaining periods it counts the base modulus. The total is therefore 2^P_W·B + A. With the default widths this is 64·B + A.

The ratio word is one flat binary number. Its low P_W bits are A and its upper B_W bits are B. For example, a ratio of 10000 gives B=156 and A=16. Both counters load at the start of every division cycle, so a new word written mid-cycle never shortens or stretches the running cycle. Standby, and the first cycle after reset, hold all counters cleared and loaded. Counting then starts with a fresh cycle when standby drops. The prescaler is modelled as synchronous logic clocked by the input clock.

Top module: `pd_divider`

## Requirements
- R1: With B ≥ A and B ≥ 1, the distance between successive `div_o` pulses is exactly 2^P_W·B + A input clock cycles (64·B + A at default widths; 4032 to 262143 is the fully continuous range there).
- R2: A is taken from `ratio_i[P_W-1:0]` and B from `ratio_i[R_W-1:P_W]`. For P_W=2 and B_W=4, the word 0b100110 (B=9, A=2) divides by 38.
- R3: Within each division cycle, `mod_hi_o` is high for exactly (2^P_W+1)·A input cycles, and these are the first cycles of the division cycle.
- R4: If B < A is programmed, A is treated as equal to B, giving a ratio of (2^P_W+1)·B, and the divider keeps producing pulses.
- R5: A B field of zero is treated as B=1, so the ratio is 2^P_W + min(A,1).
- R6: Each `div_o` pulse is high for exactly one input clock cycle.
- R7: While `standby_i` is high, `div_o` stays low and the counters are held reset. After `standby_i` falls, the first pulse comes exactly one full ratio after the first active edge.
- R8: A change of `ratio_i` inside a division cycle does not alter that cycle. The new ratio applies from the cycle that starts at the next pulse.
- R9: After asynchronous reset, `div_o` and `mod_hi_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| standby_i | input | 1 | Hold counters reset, no output pulses |
| ratio_i | input | R_W (18) | Division ratio word: B in upper B_W bits, A in lower P_W bits |
| div_o | output | 1 | One-cycle pulse per division period |
| mod_hi_o | output | 1 | Modulus control: prescaler is dividing by 2^P_W+1 |

## Verification
The bench uses a reduced configuration (4/5 prescaler, 4-bit main counter) and steps through every one of the 64 ratio words. For each word it measures two consecutive pulse periods and counts the cycles in which the modulus control is high. Words with B ≥ A test the arithmetic of the pulse-swallow relation. Words with B < A exercise the clamp, and words with B = 0 exercise the lower limit. A long standby interval shows that no pulses are produced. A ratio change partway through a cycle separates a reload at cycle start from an immediate reload.

// File: rtl/pd_div_pkg.sv
package pd_div_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;
endpackage

// File: rtl/pd_prescaler.sv
module pd_prescaler #(
  parameter int P_W = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic mod_hi_i,
  output logic tick_o
);
  localparam logic [P_W:0] LAST_HI = (P_W+1)'(1) << P_W;
  localparam logic [P_W:0] LAST_LO = LAST_HI - (P_W+1)'(1);

  logic [P_W:0] cnt_q;

  assign tick_o = (cnt_q == (mod_hi_i ? LAST_HI : LAST_LO));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || tick_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + (P_W+1)'(1);
  end
endmodule

// File: rtl/pd_swallow_cnt.sv
module pd_swallow_cnt #(
  parameter int P_W = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [P_W-1:0] a_i,
  input  logic           tick_i,
  output logic           mod_hi_o
);
  logic [P_W-1:0] rem_q;

  assign mod_hi_o = (rem_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  rem_q <= '0;
    else if (load_i)              rem_q <= a_i;
    else if (tick_i && mod_hi_o)  rem_q <= rem_q - P_W'(1);
  end
endmodule

// File: rtl/pd_main_cnt.sv
module pd_main_cnt #(
  parameter int B_W = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [B_W-1:0] b_i,
  input  logic           tick_i,
  output logic           last_o
);
  logic [B_W-1:0] rem_q;

  assign last_o = (rem_q == B_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rem_q <= '0;
    else if (load_i)  rem_q <= b_i;
    else if (tick_i)  rem_q <= rem_q - B_W'(1);
  end
endmodule

// File: rtl/pd_divider.sv
module pd_divider
  import pd_div_pkg::*;
#(
  parameter int P_W = 6,
  parameter int B_W = 12,
  localparam int R_W = P_W + B_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           standby_i,
  input  logic [R_W-1:0] ratio_i,
  output logic           div_o,
  output logic           mod_hi_o
);
  phase_e         phase_q;
  logic [B_W-1:0] b_raw, b_eff;
  logic [P_W-1:0] a_raw, a_eff;
  logic           idle, pre_tick, main_last, cyc_end, load, div_q;

  assign b_raw = ratio_i[R_W-1:P_W];
  assign a_raw = ratio_i[P_W-1:0];
  // B of zero acts as one; A never exceeds B
  assign b_eff = (b_raw == '0) ? B_W'(1) : b_raw;
  assign a_eff = (B_W'(a_raw) > b_eff) ? b_eff[P_W-1:0] : a_raw;

  assign idle    = standby_i || (phase_q == PH_IDLE);
  assign cyc_end = pre_tick && main_last && !idle;
  assign load    = idle || cyc_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      div_q   <= 1'b0;
    end else begin
      phase_q <= PH_RUN;
      div_q   <= cyc_end;
    end
  end

  pd_prescaler #(.P_W(P_W)) i_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (idle),
    .mod_hi_i (mod_hi_o),
    .tick_o   (pre_tick)
  );

  pd_swallow_cnt #(.P_W(P_W)) i_swl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .a_i      (a_eff),
    .tick_i   (pre_tick),
    .mod_hi_o (mod_hi_o)
  );

  pd_main_cnt #(.B_W(B_W)) i_main (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .b_i    (b_eff),
    .tick_i (pre_tick),
    .last_o (main_last)
  );

  assign div_o = div_q;
endmodule

// File: rtl/pd_div_chk.sv
module pd_div_chk #(
  parameter int P_W = 6,
  parameter int B_W = 12,
  localparam int R_W = P_W + B_W,
  localparam int N_W = R_W + 1
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           standby_i,
  input logic [R_W-1:0] ratio_i,
  input logic           div_o,
  input logic           mod_hi_o
);
  logic [R_W-1:0] ratio_d;
  logic [N_W-1:0] cnt_q, mcnt_q, exp_q, expm_q;
  logic           armed_q;

  function automatic logic [N_W-1:0] period_of(input logic [R_W-1:0] w);
    int b, a;
    b = int'(w[R_W-1:P_W]);
    a = int'(w[P_W-1:0]);
    if (b == 0) b = 1;
    if (a > b)  a = b;
    return N_W'(b * (1 << P_W) + a);
  endfunction

  function automatic logic [N_W-1:0] swallow_of(input logic [R_W-1:0] w);
    int b, a;
    b = int'(w[R_W-1:P_W]);
    a = int'(w[P_W-1:0]);
    if (b == 0) b = 1;
    if (a > b)  a = b;
    return N_W'(a * ((1 << P_W) + 1));
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_d <= '0;
      cnt_q   <= '0;
      mcnt_q  <= '0;
      exp_q   <= '0;
      expm_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      ratio_d <= ratio_i;
      if (standby_i) begin
        cnt_q   <= '0;
        mcnt_q  <= '0;
        exp_q   <= period_of(ratio_i);
        expm_q  <= swallow_of(ratio_i);
        armed_q <= 1'b1;
      end else if (div_o) begin
        cnt_q   <= N_W'(1);
        mcnt_q  <= N_W'(mod_hi_o);
        exp_q   <= period_of(ratio_d);
        expm_q  <= swallow_of(ratio_d);
        armed_q <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + N_W'(1);
        mcnt_q <= mcnt_q + N_W'(mod_hi_o);
      end
    end
  end

  assert_pulse_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |=> !div_o);

  assert_standby_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> !div_o);

  assert_period_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && div_o && !standby_i) |-> (cnt_q == exp_q));

  assert_swallow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && div_o && !standby_i) |-> (mcnt_q == expm_q));
endmodule

bind pd_divider pd_div_chk #(.P_W(P_W), .B_W(B_W)) i_pd_div_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .standby_i (standby_i),
  .ratio_i   (ratio_i),
  .div_o     (div_o),
  .mod_hi_o  (mod_hi_o)
);

// File: tb/test_pd_divider.sv
module test_pd_divider;
  localparam int TP   = 10;
  localparam int TP_W = 2;
  localparam int TB_W = 4;
  localparam int TR_W = TP_W + TB_W;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            standby_i = 1'b1;
  logic [TR_W-1:0] ratio_i = '0;
  logic            div_o, mod_hi_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(TP/2) clk_i = ~clk_i;

  pd_divider #(.P_W(TP_W), .B_W(TB_W)) i_pd_divider (
    .clk_i(clk_i), .rst_ni(rst_ni), .standby_i(standby_i),
    .ratio_i(ratio_i), .div_o(div_o), .mod_hi_o(mod_hi_o)
  );

  function automatic int eff_b(input int w);
    int b = w >> TP_W;
    return (b == 0) ? 1 : b;
  endfunction
  function automatic int eff_a(input int w);
    int a = w & ((1 << TP_W) - 1);
    return (a > eff_b(w)) ? eff_b(w) : a;
  endfunction
  function automatic int exp_n(input int w);
    return eff_b(w) * (1 << TP_W) + eff_a(w);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Starts at a negedge; ends at the negedge where div_o is seen high.
  task automatic measure(output int edges, output int mods, output int early,
                         input int chg_at, input int chg_w);
    edges = 0; mods = 0; early = 0;
    forever begin
      mods += int'(mod_hi_o);
      @(posedge clk_i);
      edges++;
      @(negedge clk_i);
      if (edges == chg_at) ratio_i = TR_W'(chg_w);
      if (edges == 1 && div_o) early = 1;
      if (div_o || edges > 400) break;
    end
  endtask

  task automatic release_with(input int w);
    @(negedge clk_i);
    standby_i = 1'b1;
    ratio_i   = TR_W'(w);
    repeat (2) @(negedge clk_i);
    standby_i = 1'b0;
  endtask

  initial begin
    #(TP * 150000);
    if (!done) begin
      failures++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int e, m, early, quiet;
    #(TP * 2 + 3);
    check(div_o == 1'b0 && mod_hi_o == 1'b0, "R9 reset", int'({div_o, mod_hi_o}), 0);
    rst_ni = 1'b1;

    // R7: long standby stays quiet
    @(negedge clk_i);
    ratio_i = TR_W'(16);
    quiet = 0;
    repeat (200) begin
      @(negedge clk_i);
      quiet += int'(div_o);
    end
    check(quiet == 0, "R7 standby pulses", quiet, 0);

    // R2: field split, B=9 A=2 -> 38
    release_with(6'b100110);
    measure(e, m, early, -1, 0);
    check(e == 38, "R2 field split", e, 38);

    // Sweep every word: R1, R4, R5, R3, R6, R7
    for (int w = 0; w < (1 << TR_W); w++) begin
      string tag;
      int b = w >> TP_W;
      int a = w & ((1 << TP_W) - 1);
      tag = (b == 0) ? "R5 zero B" : (a > b) ? "R4 clamp" : "R1 ratio";
      release_with(w);
      measure(e, m, early, -1, 0);
      check(e == exp_n(w), "R7 first period after standby", e, exp_n(w));
      measure(e, m, early, -1, 0);
      check(e == exp_n(w), tag, e, exp_n(w));
      check(m == eff_a(w) * ((1 << TP_W) + 1), "R3 swallow cycles", m, eff_a(w) * ((1 << TP_W) + 1));
      check(early == 0, "R6 pulse width", early, 0);
    end

    // R8: change mid-cycle, 20 -> 40
    release_with(20);
    measure(e, m, early, 5, 40);
    check(e == 20, "R8 running cycle kept", e, 20);
    measure(e, m, early, -1, 0);
    check(e == 40, "R8 new ratio next cycle", e, 40);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule